// File: doc/BRIEF.md
# Interleaved Parallel Unit Dispatcher

This block raises the throughput of a slow combinational function without cutting that function into pipeline stages. It holds N identical copies of a unit whose result settles N clock cycles after its operand is presented. Operands arrive at most one per cycle. A write pointer steers each accepted operand into the input register of the next copy in round-robin order. A read pointer walks the copies in the same order and drives the result of the oldest finished copy onto a single output.

In steady state the block delivers one result per clock, which is N results per unit delay. Each item still sees exactly one unit delay of latency, and items leave in the order they arrived. The unit's real function is outside this block. A fixed stand-in computes the result as the operand rotated left by one bit and then XORed with a key parameter.

Top module: `ilv_dispatch`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `in_sel` and `out_sel` are 0 and `out_valid` is 0. Any item in flight when reset is asserted is discarded and never appears at the output.
- R2: `in_sel` gives the index of the copy that captures the operand at the next edge. It advances by one, wrapping from N-1 to 0, after every cycle with `in_valid` high, and holds its value after a cycle with `in_valid` low.
- R3: `out_valid` is high in cycle c+N exactly when `in_valid` was high in cycle c, with no extra or missing results.
- R4: Results leave in input order. Each result equals its operand rotated left by one bit (the MSB moves to bit 0) and then XORed with `KEY`.
- R5: `out_sel` is the index of the copy whose result is on `out_data`. It equals the `in_sel` value that was shown when that item was accepted. It advances by one, with wrap, after each cycle with `out_valid` high, and otherwise holds.
- R6: `out_data` is all zeros in any cycle where `out_valid` is low.
- R7: Back-to-back input on every cycle is accepted without loss, giving one result per cycle. Idle gaps of any length between inputs do not change the result values or their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | W | Operand |
| in_sel | output | log2(N) | Copy that captures the next operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | W | Result, zero when not valid |
| out_sel | output | log2(N) | Copy driving the result |

## Verification
The hardest case to reach is a copy whose result is being read out in the same cycle that a new operand is written into it. This only happens when input arrives on every cycle, so the pointers wrap onto each other exactly. The stimulus forces this with long unbroken bursts and with bursts of exactly N items. It then mixes in random idle gaps, so the read pointer trails the write pointer by varying amounts. A reset is applied while items are in flight, to show they are discarded.

// File: rtl/ilv_dispatch.sv
module ilv_dispatch #(
  parameter int N = 4,
  parameter int W = 16,
  parameter logic [W-1:0] KEY = 16'hA5C3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [W-1:0]                  in_data,
  output logic [((N>1)?$clog2(N):1)-1:0] in_sel,
  output logic                          out_valid,
  output logic [W-1:0]                  out_data,
  output logic [((N>1)?$clog2(N):1)-1:0] out_sel
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);
  localparam logic [PW-1:0] LAST = PW'(N - 1);
  localparam logic [CW-1:0] LAT  = CW'(N);

  logic [PW-1:0]         wr_ptr, rd_ptr;
  logic [N-1:0][W-1:0]   res;
  logic [N-1:0]          done;

  for (genvar g = 0; g < N; g++) begin : g_unit
    logic [W-1:0]  hold;
    logic          busy;
    logic [CW-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold <= '0;
        busy <= 1'b0;
        age  <= '0;
      end else if (in_valid && wr_ptr == PW'(g)) begin
        hold <= in_data;
        busy <= 1'b1;
        age  <= CW'(1);
      end else if (busy) begin
        if (age == LAT) busy <= 1'b0;
        else            age  <= age + 1'b1;
      end
    end

    assign res[g]  = {hold[W-2:0], hold[W-1]} ^ KEY;
    assign done[g] = busy && (age == LAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else if (in_valid) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ptr <= '0;
    else if (out_valid) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  end

  assign in_sel    = wr_ptr;
  assign out_sel   = rd_ptr;
  assign out_valid = done[rd_ptr];
  assign out_data  = out_valid ? res[rd_ptr] : '0;
endmodule

module ilv_dispatch_chk #(
  parameter int N = 4,
  parameter int W = 16,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [PW-1:0] in_sel,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic [PW-1:0] out_sel
);
  localparam logic [PW-1:0] LAST = PW'(N - 1);
  logic [N-1:0] vhist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vhist <= '0;
    else        vhist <= (vhist << 1) | N'(in_valid);
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (in_sel == '0 && out_sel == '0 && !out_valid));

  assert_in_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> in_sel == (($past(in_sel) == LAST) ? '0 : $past(in_sel) + 1'b1));

  assert_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(in_sel));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vhist[N-1]);

  assert_out_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_sel == (($past(out_sel) == LAST) ? '0 : $past(out_sel) + 1'b1));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> $stable(out_sel));

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);
endmodule

bind ilv_dispatch ilv_dispatch_chk #(.N(N), .W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
  .out_valid(out_valid), .out_data(out_data), .out_sel(out_sel)
);

// File: tb/ilv_dispatch_tb.sv
module ilv_dispatch_tb;
  localparam int N = 4;
  localparam int W = 16;
  localparam logic [W-1:0] KEY = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [1:0] in_sel, out_sel;
  logic out_valid;
  logic [W-1:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] q_res[$];
  int q_unit[$];
  int q_age[$];
  int m_wr = 0;
  int m_rd = 0;

  always #2.5 clk = ~clk;

  ilv_dispatch #(.N(N), .W(W), .KEY(KEY)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sel(in_sel), .out_valid(out_valid), .out_data(out_data), .out_sel(out_sel)
  );

  function automatic logic [W-1:0] ref_fn(input logic [W-1:0] x);
    logic [W-1:0] r;
    r = (x << 1) | (x >> (W - 1));
    return r ^ KEY;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [W-1:0] d);
    bit ev;
    @(negedge clk);
    ev = (q_age.size() > 0) && (q_age[0] == N);
    chk("R3 out_valid", out_valid, ev);
    chk("R2 in_sel", in_sel, m_wr);
    chk("R5 out_sel", out_sel, m_rd);
    if (ev) begin
      chk("R4/R7 out_data", out_data, q_res[0]);
      chk("R5 out_sel matches capture", out_sel, q_unit[0]);
    end else begin
      chk("R6 out_data zero", out_data, 0);
    end
    rst_n = r;
    in_valid = v;
    in_data = d;
    if (!r) begin
      q_res.delete(); q_unit.delete(); q_age.delete();
      m_wr = 0; m_rd = 0;
    end else begin
      if (ev) begin
        void'(q_res.pop_front()); void'(q_unit.pop_front()); void'(q_age.pop_front());
        m_rd = (m_rd + 1) % N;
      end
      foreach (q_age[i]) q_age[i]++;
      if (v) begin
        q_res.push_back(ref_fn(d)); q_unit.push_back(m_wr); q_age.push_back(1);
        m_wr = (m_wr + 1) % N;
      end
    end
  endtask

  initial begin
    #1;
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset in_sel", in_sel, 0);
    chk("R1 reset out_sel", out_sel, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    step(1, 0, 0);
    // R7: long unbroken burst, unit reused on the cycle it is read
    for (int i = 0; i < 40; i++) step(1, 1, W'(16'h1000 + i * 37));
    for (int i = 0; i < 8; i++) step(1, 0, 0);
    // single items and exact N bursts with gaps
    step(1, 1, 16'h8001);
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    for (int i = 0; i < N; i++) step(1, 1, W'(16'hFFFF - i));
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(1, 1, 16'h0000);
    step(1, 1, 16'h8000);
    // R7: random gaps
    for (int i = 0; i < 400; i++) step(1, ($urandom % 3) != 0, W'($urandom));
    // R1: reset with items in flight
    for (int i = 0; i < 3; i++) step(1, 1, W'(16'h4242 + i));
    step(0, 0, 0);
    step(0, 0, 0);
    step(1, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 1, W'(i * 4099));
    for (int i = 0; i < 10; i++) step(1, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule